// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-vector message table and the pending bit array for a configurable number of message-signalled interrupt vectors. Software reaches both through a 32-bit word register port. The capability control word is written through a separate plain port, and its enable and mask-all bits set the function-level mask. Device logic declares which vectors are in use and raises interrupt requests by vector number.

A request for an unmasked vector becomes a message that carries the entry's 64-bit address and 32-bit data. A request for a masked vector is held as a pending bit. When the effective mask of a pending vector drops, either through a table write or through a control write, the held message is released. All messages leave on a valid/ready stream. Once `msg_valid` is high, it stays high and `msg_vec`, `msg_addr` and `msg_data` stay unchanged until the cycle in which `msg_ready` is high. A message is taken on any rising clock edge where both are high. Vectors that become deliverable together leave in ascending vector order, one per handshake.

Top module: `msix_vector_ctrl`

## Requirements
- R1: Each vector owns 16 bytes of the table, selected by byte address divided by 16. Word 0 is address bits 31:0, word 1 is address bits 63:32, word 2 is the message data, and word 3 is the control word. Only bit 0 of the control word is stored, as the per-vector mask; its other bits read 0. Table accesses to a vector at or beyond NUM_VEC are ignored on write and read 0.
- R2: With `reg_pba` high, word k of the pending array returns the pending bit of vector 32k+i in bit i. Bits for vectors at or beyond NUM_VEC read 0, including the padding up to a multiple of 64 vectors. Writes to the pending array have no effect.
- R3: The control word has enable at bit 15 and mask-all at bit 14. It reads back with bits 10:0 equal to NUM_VEC−1 and bits 13:11 equal to 0. The function is masked when enable is 0 or mask-all is 1.
- R4: A request whose vector is at or beyond NUM_VEC, or whose vector is not marked in use, has no effect.
- R5: A request for a vector that is masked (by its own mask or by the function mask) sets that vector's pending bit and produces no message.
- R6: A request for an unmasked vector produces a message that carries the vector number and the entry's address and data as they stand when the message is loaded onto the output.
- R7: A pending vector whose effective mask becomes clear has its pending bit cleared and its message queued, whether the unmask came from a table write or from a control write.
- R8: Queued vectors leave in ascending vector order, one per handshake. The message outputs hold steady while `msg_ready` is low.
- R9: After reset, all pending bits are 0, enable and mask-all are 0, every address and data word is 0, every per-vector mask is 1, no vector is in use, and no message is offered.
- R10: Marking a vector not in use clears its pending bit.
- R11: Further requests for a vector that is already queued but not yet on the output merge into a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read value |
| reg_wr | input | 1 | Register port write strobe |
| reg_pba | input | 1 | 1 selects the pending array, 0 selects the table |
| reg_addr | input | VW+4 | Byte address of a 32-bit word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| use_en | input | 1 | Update the in-use flag of `use_vec` |
| use_on | input | 1 | New in-use flag value |
| use_vec | input | VW+1 | Vector whose in-use flag changes |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VW+1 | Requested vector |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vec | output | VW | Vector of the offered message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Requests are driven under four mask states: the function fully masked, the function enabled with the vector masked, both masks clear, and mask-all set over unmasked vectors. These states separate dropping a request, holding it as pending and sending it at once. Requests to out-of-range and unused vectors show that discarding is distinct from pending. Several vectors are raised in descending order under mask-all and released by one control write while the stream is stalled, which shows both the ascending release order and that the outputs hold under back-pressure. Repeated requests behind a stalled output show the merge. A use drop and a reset in the middle of the run show that held state is cleared.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef enum logic [1:0] {
    EW_ADDR_LO = 2'd0,
    EW_ADDR_HI = 2'd1,
    EW_DATA    = 2'd2,
    EW_CTRL    = 2'd3
  } entry_word_e;

  localparam int CTRL_EN_BIT   = 15;
  localparam int CTRL_MALL_BIT = 14;
  localparam int TSIZE_W       = 11;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NVEC = 8,
  parameter int VW   = (NVEC > 1) ? $clog2(NVEC) : 1,
  parameter int AW   = VW + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NVEC-1:0] vmask,
  input  logic [VW-1:0]   sel_vec,
  output logic [63:0]     sel_addr,
  output logic [31:0]     sel_data
);
  logic [31:0] alo [NVEC];
  logic [31:0] ahi [NVEC];
  logic [31:0] dat [NVEC];
  logic [VW-1:0] wvec;
  entry_word_e   word;
  logic          in_rng;

  assign wvec   = addr[AW-1:4];
  assign word   = entry_word_e'(addr[3:2]);
  assign in_rng = int'(wvec) < NVEC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) begin
        alo[i] <= '0;
        ahi[i] <= '0;
        dat[i] <= '0;
      end
      vmask <= '1;
    end else if (wr && in_rng) begin
      case (word)
        EW_ADDR_LO: alo[wvec] <= wdata;
        EW_ADDR_HI: ahi[wvec] <= wdata;
        EW_DATA:    dat[wvec] <= wdata;
        default:    vmask[wvec] <= wdata[0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (in_rng) begin
      case (word)
        EW_ADDR_LO: rdata = alo[wvec];
        EW_ADDR_HI: rdata = ahi[wvec];
        EW_DATA:    rdata = dat[wvec];
        default:    rdata = {31'd0, vmask[wvec]};
      endcase
    end
  end

  assign sel_addr = {ahi[sel_vec], alo[sel_vec]};
  assign sel_data = dat[sel_vec];
endmodule

// File: rtl/msix_pending.sv
module msix_pending #(
  parameter int NVEC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] mask,
  input  logic [NVEC-1:0] hit,
  input  logic [NVEC-1:0] drop,
  input  logic [NVEC-1:0] take,
  output logic [NVEC-1:0] pend,
  output logic [NVEC-1:0] sendq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      sendq <= '0;
    end else begin
      // masked requests accumulate; unmasked pending bits move to the send set
      pend  <= ((pend | hit) & mask) & ~drop;
      sendq <= (sendq & ~take) | ((pend | hit) & ~mask);
    end
  end
endmodule

// File: rtl/msix_emit.sv
module msix_emit #(
  parameter int NVEC = 8,
  parameter int VW   = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] sendq,
  output logic [VW-1:0]   pick_vec,
  output logic [NVEC-1:0] take,
  input  logic [63:0]     tab_addr,
  input  logic [31:0]     tab_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VW-1:0]   out_vec,
  output logic [63:0]     out_addr,
  output logic [31:0]     out_data
);
  logic any, load;

  always_comb begin
    pick_vec = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (sendq[i]) pick_vec = VW'(i);
    end
  end

  assign any  = |sendq;
  assign load = any && (!out_valid || out_ready);

  always_comb begin
    take = '0;
    if (load) take[pick_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_vec   <= pick_vec;
      out_addr  <= tab_addr;
      out_data  <= tab_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int AW = VW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          reg_wr,
  input  logic          reg_pba,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          use_en,
  input  logic          use_on,
  input  logic [VW:0]   use_vec,
  input  logic          irq_valid,
  input  logic [VW:0]   irq_vec,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [VW-1:0] msg_vec,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  localparam int PBA_BITS  = ((NUM_VEC + 63) / 64) * 64;
  localparam int PBA_WORDS = PBA_BITS / 32;

  logic en_q, mall_q, func_mask;
  logic [NUM_VEC-1:0] vmask, mask_vec, pend_vec, sendq, take;
  logic [NUM_VEC-1:0] used_q, hit, drop;
  logic [31:0] tab_rdata, pba_rdata;
  logic [VW-1:0] pick_vec;
  logic [63:0] tab_addr;
  logic [31:0] tab_data;
  logic [PBA_BITS-1:0] pend_pad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mall_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q   <= cfg_wdata[CTRL_EN_BIT];
      mall_q <= cfg_wdata[CTRL_MALL_BIT];
    end
  end
  assign cfg_rdata = {en_q, mall_q, 3'b000, TSIZE_W'(NUM_VEC - 1)};
  assign func_mask = !en_q || mall_q;
  assign mask_vec  = vmask | {NUM_VEC{func_mask}};

  always_comb begin
    hit  = '0;
    drop = '0;
    if (irq_valid && int'(irq_vec) < NUM_VEC && used_q[irq_vec[VW-1:0]])
      hit[irq_vec[VW-1:0]] = 1'b1;
    if (use_en && !use_on && int'(use_vec) < NUM_VEC)
      drop[use_vec[VW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else if (use_en && int'(use_vec) < NUM_VEC) used_q[use_vec[VW-1:0]] <= use_on;
  end

  msix_table #(.NVEC(NUM_VEC), .VW(VW), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && !reg_pba), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(tab_rdata), .vmask(vmask),
    .sel_vec(pick_vec), .sel_addr(tab_addr), .sel_data(tab_data)
  );

  msix_pending #(.NVEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .mask(mask_vec), .hit(hit), .drop(drop),
    .take(take), .pend(pend_vec), .sendq(sendq)
  );

  msix_emit #(.NVEC(NUM_VEC), .VW(VW)) u_emit (
    .clk(clk), .rst_n(rst_n), .sendq(sendq), .pick_vec(pick_vec), .take(take),
    .tab_addr(tab_addr), .tab_data(tab_data), .out_valid(msg_valid),
    .out_ready(msg_ready), .out_vec(msg_vec), .out_addr(msg_addr), .out_data(msg_data)
  );

  assign pend_pad = PBA_BITS'(pend_vec);
  always_comb begin
    int widx;
    widx = int'(reg_addr[AW-1:2]);
    pba_rdata = '0;
    if (widx < PBA_WORDS) pba_rdata = pend_pad[widx*32 +: 32];
  end
  assign reg_rdata = reg_pba ? pba_rdata : tab_rdata;
endmodule

// File: rtl/msix_vector_ctrl_chk.sv
module msix_vector_ctrl_chk #(
  parameter int NUM_VEC = 8,
  parameter int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [VW-1:0]      msg_vec,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic               irq_valid,
  input logic [VW:0]        irq_vec,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] mask
);
  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid);

  p_hold_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> $stable(msg_vec) && $stable(msg_addr) && $stable(msg_data));

  p_vec_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> int'(msg_vec) < NUM_VEC);

  p_pend_only_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0));

  p_oor_no_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && int'(irq_vec) >= NUM_VEC |=> ((pend & ~$past(pend)) == '0));
endmodule

bind msix_vector_ctrl msix_vector_ctrl_chk #(.NUM_VEC(NUM_VEC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data),
  .irq_valid(irq_valid), .irq_vec(irq_vec), .pend(pend_vec), .mask(mask_vec)
);

// File: tb/sim_msix_vector_ctrl.sv
module sim_msix_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 10;
  localparam int VW = 4;
  localparam int AW = VW + 4;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [15:0] cfg_wdata = '0; logic [15:0] cfg_rdata;
  logic reg_wr = 0, reg_pba = 0; logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic use_en = 0, use_on = 0; logic [VW:0] use_vec = '0;
  logic irq_valid = 0; logic [VW:0] irq_vec = '0;
  logic msg_valid, msg_ready = 1; logic [VW-1:0] msg_vec;
  logic [63:0] msg_addr; logic [31:0] msg_data;

  msix_vector_ctrl #(.NUM_VEC(N)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int log_q[$];
  bit done = 0;

  // behavioural reference state
  bit m_en, m_ma, m_vm[N], m_used[N], m_pend[N], m_sq[N];
  logic [31:0] m_alo[N], m_ahi[N], m_dat[N];
  bit m_ov; int m_ovec; logic [63:0] m_oa; logic [31:0] m_od;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit mmask(int v);
    return !m_en || m_ma || m_vm[v];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ma = 0; m_ov = 0; m_ovec = 0; m_oa = '0; m_od = '0;
      for (int v = 0; v < N; v++) begin
        m_vm[v] = 1; m_used[v] = 0; m_pend[v] = 0; m_sq[v] = 0;
        m_alo[v] = '0; m_ahi[v] = '0; m_dat[v] = '0;
      end
    end else begin
      bit msk[N], np[N], nq[N];
      int pk, hv;
      pk = -1; hv = -1;
      for (int v = 0; v < N; v++) begin msk[v] = mmask(v); nq[v] = m_sq[v]; end
      for (int v = N - 1; v >= 0; v--) if (m_sq[v]) pk = v;
      if (pk >= 0 && (!m_ov || msg_ready)) begin
        nq[pk] = 0; m_ov = 1; m_ovec = pk; m_oa = {m_ahi[pk], m_alo[pk]}; m_od = m_dat[pk];
      end else if (msg_ready) m_ov = 0;
      if (irq_valid && int'(irq_vec) < N && m_used[irq_vec]) hv = int'(irq_vec);
      for (int v = 0; v < N; v++) begin
        np[v] = (m_pend[v] || v == hv) && msk[v];
        if ((m_pend[v] || v == hv) && !msk[v]) nq[v] = 1;
      end
      if (use_en && int'(use_vec) < N) begin
        m_used[use_vec] = use_on;
        if (!use_on) np[use_vec] = 0;
      end
      if (reg_wr && !reg_pba && int'(reg_addr >> 4) < N) begin
        int vv; vv = int'(reg_addr >> 4);
        case (reg_addr[3:2])
          2'd0: m_alo[vv] = reg_wdata;
          2'd1: m_ahi[vv] = reg_wdata;
          2'd2: m_dat[vv] = reg_wdata;
          default: m_vm[vv] = reg_wdata[0];
        endcase
      end
      if (cfg_wr) begin m_en = cfg_wdata[15]; m_ma = cfg_wdata[14]; end
      for (int v = 0; v < N; v++) begin m_pend[v] = np[v]; m_sq[v] = nq[v]; end
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r; r = '0;
    if (reg_pba) begin
      for (int i = 0; i < 32; i++)
        if (int'(reg_addr >> 2) * 32 + i < N) r[i] = m_pend[int'(reg_addr >> 2) * 32 + i];
    end else if (int'(reg_addr >> 4) < N) begin
      int vv; vv = int'(reg_addr >> 4);
      case (reg_addr[3:2])
        2'd0: r = m_alo[vv];
        2'd1: r = m_ahi[vv];
        2'd2: r = m_dat[vv];
        default: r = {31'd0, m_vm[vv]};
      endcase
    end
    return r;
  endfunction

  // per-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk("R3 cfg_rdata", 64'(cfg_rdata), 64'({m_en, m_ma, 3'b000, 11'(N - 1)}));
      chk(reg_pba ? "R2 pba read" : "R1 table read", 64'(reg_rdata), 64'(exp_rdata()));
      chk("R8 msg_valid", 64'(msg_valid), 64'(m_ov));
      if (m_ov) begin
        chk("R8 msg_vec", 64'(msg_vec), 64'(m_ovec));
        chk("R6 msg_addr", msg_addr, m_oa);
        chk("R6 msg_data", 64'(msg_data), 64'(m_od));
      end
      if (msg_valid && msg_ready) log_q.push_back(int'(msg_vec));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cfg(input logic [15:0] v);
    @(negedge clk); #1 cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); #1 cfg_wr = 0;
  endtask
  task automatic twr(input bit pba, input int a, input logic [31:0] d);
    @(negedge clk); #1 reg_wr = 1; reg_pba = pba; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(input bit pba, input int a, output logic [31:0] d);
    @(negedge clk); #1 reg_pba = pba; reg_addr = AW'(a);
    #(CLK_PERIOD/4); d = reg_rdata;
  endtask
  task automatic irq(input int v);
    @(negedge clk); #1 irq_valid = 1; irq_vec = (VW+1)'(v);
    @(negedge clk); #1 irq_valid = 0;
  endtask
  task automatic setuse(input int v, input bit on);
    @(negedge clk); #1 use_en = 1; use_on = on; use_vec = (VW+1)'(v);
    @(negedge clk); #1 use_en = 0;
  endtask
  task automatic ready(input bit r);
    @(negedge clk); #1 msg_ready = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int c5;
    idle(3); #1 rst_n = 1;
    // R9 reset state
    rd(0, 3*16 + 12, d); chk("R9 entry mask after reset", 64'(d), 64'd1);
    rd(0, 3*16, d);      chk("R9 entry addr after reset", 64'(d), 64'd0);
    rd(1, 0, d);         chk("R9 pending after reset", 64'(d), 64'd0);
    chk("R9 cfg after reset", 64'(cfg_rdata), 64'h0009);
    chk("R9 no message after reset", 64'(msg_valid), 64'd0);

    for (int v = 0; v < N; v++) if (v != 7) setuse(v, 1);
    for (int v = 0; v < N; v++) begin
      twr(0, v*16 + 0, 32'h1000_0000 + 32'(v*16));
      twr(0, v*16 + 4, 32'h0000_00A5);
      twr(0, v*16 + 8, 32'h0000_00D0 + 32'(v));
    end
    rd(0, 2*16 + 8, d); chk("R1 data word", 64'(d), 64'h0D2);
    rd(0, 2*16 + 4, d); chk("R1 addr high word", 64'(d), 64'h0A5);
    twr(0, 4*16 + 12, 32'hFFFF_FFFF);
    rd(0, 4*16 + 12, d); chk("R1 ctrl upper bits", 64'(d), 64'd1);
    twr(0, 12*16, 32'h1234_5678);
    rd(0, 12*16, d); chk("R1 out-of-range entry", 64'(d), 64'd0);

    cfg(16'h8000);
    log_q.delete();
    irq(3); idle(3);
    rd(1, 0, d); chk("R5 pending set on masked vector", 64'(d), 64'h8);
    chk("R5 no message when masked", 64'(log_q.size()), 64'd0);
    irq(12); irq(7); idle(3);
    rd(1, 0, d); chk("R4 discarded requests", 64'(d), 64'h8);
    twr(1, 0, 32'hFFFF_FFFF);
    rd(1, 0, d); chk("R2 pending write ignored", 64'(d), 64'h8);
    rd(1, 4, d); chk("R2 padding reads zero", 64'(d), 64'd0);

    twr(0, 3*16 + 12, 32'h0); idle(4);
    rd(1, 0, d); chk("R7 pending cleared on unmask", 64'(d), 64'd0);
    chk("R7 released message", 64'(log_q.size() == 1 && log_q[0] == 3), 64'd1);

    log_q.delete();
    irq(3); idle(4);
    chk("R6 unmasked request sent", 64'(log_q.size() == 1 && log_q[0] == 3), 64'd1);

    cfg(16'hC000);
    twr(0, 1*16 + 12, 0); twr(0, 5*16 + 12, 0); twr(0, 9*16 + 12, 0);
    irq(9); irq(5); irq(1); idle(2);
    rd(1, 0, d); chk("R5 held under mask-all", 64'(d), 64'h222);
    log_q.delete();
    ready(0); cfg(16'h8000); idle(5);
    ready(1); idle(6);
    chk("R8 count", 64'(log_q.size()), 64'd3);
    if (log_q.size() == 3)
      chk("R8 ascending order", 64'(log_q[0] == 1 && log_q[1] == 5 && log_q[2] == 9), 64'd1);

    log_q.delete();
    ready(0); irq(5); irq(5); irq(5); idle(2);
    ready(1); idle(5);
    c5 = 0; foreach (log_q[i]) if (log_q[i] == 5) c5++;
    chk("R11 merged requests", 64'(c5), 64'd2);

    cfg(16'hC000); irq(1); idle(2);
    rd(1, 0, d); chk("R10 pending before drop", 64'(d), 64'h2);
    setuse(1, 0);
    rd(1, 0, d); chk("R10 drop clears pending", 64'(d), 64'd0);
    log_q.delete();
    cfg(16'h8000); idle(4);
    chk("R10 nothing released", 64'(log_q.size()), 64'd0);

    cfg(16'hC000); irq(9); idle(2);
    @(negedge clk); #1 rst_n = 0; idle(2); #1 rst_n = 1;
    rd(1, 0, d);          chk("R9 pending cleared by reset", 64'(d), 64'd0);
    rd(0, 9*16 + 12, d);  chk("R9 mask set by reset", 64'(d), 64'd1);
    rd(0, 9*16 + 8, d);   chk("R9 data zeroed by reset", 64'(d), 64'd0);
    chk("R9 cfg cleared by reset", 64'(cfg_rdata), 64'h0009);
    idle(2);
    finish_run();
  end
endmodule